// File: doc/BRIEF.md
# Programmable Reed-Solomon Check-Symbol Encoder

This block is a systematic Reed-Solomon encoder over GF(2^8) for a byte stream. Software picks the number of check symbols (the parity count, `npar`, from 2 to 20) and the total codeword length (`nlen`) at run time. After each legal configuration the block spends `npar` clocks building the generator polynomial. It multiplies in one first-degree root factor per clock, and the roots run upward from alpha^120.

Each block enters as a run of message bytes. The run starts with a byte flagged as start of block and ends with `npar` placeholder bytes. The block passes every message byte through unchanged. As the placeholders arrive, it replaces them with the remainder of a shift-register division by the generator. Every accepted input byte produces exactly one output byte one clock later, so the latency is the same whatever the block length or content.

An out-of-range configuration is flagged and rejected. Until a later legal configuration arrives, no block is encoded.

Top module: `rs_encoder`

## Requirements
- R1: While reset is high and afterwards until the first legal configuration, out_valid, out_sob, busy and cfg_err are low and every input byte is ignored (no out_valid follows it).
- R2: A cfg_load with cfg_npar in 2..20 and cfg_nlen in cfg_npar+1..255 is legal. From the next cycle cfg_err is low and busy is high for exactly cfg_npar consecutive cycles.
- R3: An illegal cfg_load sets cfg_err from the next cycle, leaves it set until a legal cfg_load, does not raise busy, and makes the block ignore input bytes while cfg_err is set.
- R4: Field arithmetic uses the primitive polynomial x^8+x^7+x^2+x+1 (reduction byte 0x87) with alpha = 0x02. The generator is the product of (x + alpha^i) for i = 120..119+npar. Check bytes are the remainder of m(x)·x^npar divided by that generator, and the first message byte is the highest-degree coefficient. Every complete output codeword therefore evaluates to zero at each generator root.
- R5: A block starts on a byte with in_valid and in_sob both high. Its accepted byte positions 0..K-1 (K = nlen - npar) are message bytes and positions K..nlen-1 are placeholders. After position nlen-1 the block is closed.
- R6: Each accepted byte produces out_valid exactly one cycle later, and out_sob is high with it only for position 0. Cycles without an accepted byte produce no out_valid, so idle gaps inside a block are allowed.
- R7: Message bytes appear on out_data unchanged. The values of the placeholder bytes have no effect on any output byte.
- R8: The check bytes leave in descending degree: the coefficient of x^(npar-1) goes out first and the constant term goes out last.
- R9: An in_valid byte without in_sob is ignored when no block is open. A byte with in_sob in the middle of a block abandons that block and starts a new one.
- R10: Input bytes that arrive while busy is high are ignored.
- R11: When cfg_load and in_valid are high in the same cycle, the byte is dropped and any open block is abandoned. Later bytes without in_sob are then ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Loads cfg_npar and cfg_nlen this cycle |
| cfg_npar | input | 5 | Number of check symbols requested |
| cfg_nlen | input | 8 | Codeword length in bytes requested |
| in_valid | input | 1 | Input byte present |
| in_sob | input | 1 | Input byte is position 0 of a block |
| in_data | input | 8 | Input byte (message or placeholder) |
| out_valid | output | 1 | Output byte present |
| out_sob | output | 1 | Output byte is position 0 of a block |
| out_data | output | 8 | Message byte or computed check byte |
| busy | output | 1 | Generator polynomial is being built |
| cfg_err | output | 1 | Last loaded configuration was illegal |

## Verification
Two events can land in the same clock: a configuration load and the arrival of a block byte. The bench provokes this in the middle of an open block by raising cfg_load and in_valid together. It expects no output in the following cycle. After the rebuild it expects a byte without in_sob to be ignored, and it then encodes a fresh block correctly under the new parity count. A second meeting point is back-to-back blocks, where the last placeholder of one block is followed at once by the start byte of the next. Each codeword is judged two ways: against a bench-computed remainder, and by evaluating it at every generator root.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;

    localparam int SYM_W      = 8;
    localparam int MIN_NPAR   = 2;
    localparam int MAX_NPAR   = 20;
    localparam int NPAR_W     = $clog2(MAX_NPAR + 1);
    localparam int LEN_W      = SYM_W;
    localparam int MAX_LEN    = (1 << LEN_W) - 1;
    localparam int FIRST_ROOT = 120;
    localparam logic [SYM_W-1:0] FIELD_LOW = 8'h87;

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic [NPAR_W-1:0] npar;
        logic [LEN_W-1:0]  nlen;
    } cfg_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_DATA,
        SEQ_PARITY
    } seq_state_e;

    typedef struct packed {
        logic step;   // a byte is consumed this cycle
        logic clear;  // byte is position 0: start from an empty remainder
        logic feed;   // message byte: division feedback active
    } lfsr_ctl_t;

    function automatic sym_t gf_xtime(sym_t a);
        sym_t sh;
        sh = {a[SYM_W-2:0], 1'b0};
        return a[SYM_W-1] ? (sh ^ FIELD_LOW) : sh;
    endfunction

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t acc;
        sym_t t;
        acc = '0;
        t   = a;
        for (int i = 0; i < SYM_W; i++) begin
            if (b[i]) acc = acc ^ t;
            t = gf_xtime(t);
        end
        return acc;
    endfunction

    function automatic sym_t gf_alpha_pow(int e);
        sym_t t;
        t = sym_t'(1);
        for (int i = 0; i < e; i++) t = gf_xtime(t);
        return t;
    endfunction

    function automatic logic cfg_ok(logic [NPAR_W-1:0] np, logic [LEN_W-1:0] nl);
        int p;
        int n;
        p = int'(np);
        n = int'(nl);
        return (p >= MIN_NPAR) && (p <= MAX_NPAR) && (n >= p + 1) && (n <= MAX_LEN);
    endfunction

    localparam sym_t ALPHA_FIRST = gf_alpha_pow(FIRST_ROOT);

endpackage

// File: rtl/rs_gen_builder.sv
module rs_gen_builder
    import rs_enc_pkg::*;
#(
    parameter int MAXP = MAX_NPAR
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       start,
    input  logic [NPAR_W-1:0]          npar,
    output logic                       busy,
    output logic [MAXP-1:0][SYM_W-1:0] gen_coef
);

    sym_t              poly_q [MAXP+1];
    sym_t              pass_d [MAXP+1];
    sym_t              root_q;
    logic [NPAR_W-1:0] left_q;
    logic              busy_q;

    // One pass multiplies the running product by (x + root).
    for (genvar j = 0; j <= MAXP; j++) begin : g_coef
        localparam sym_t INIT = (j == 0) ? sym_t'(1) : sym_t'(0);

        if (j == 0) begin : g_low
            assign pass_d[j] = gf_mul(poly_q[j], root_q);
        end else begin : g_high
            assign pass_d[j] = poly_q[j-1] ^ gf_mul(poly_q[j], root_q);
        end

        always_ff @(posedge clk) begin
            if (rst)         poly_q[j] <= '0;
            else if (start)  poly_q[j] <= INIT;
            else if (busy_q) poly_q[j] <= pass_d[j];
        end

        if (j < MAXP) begin : g_out
            assign gen_coef[j] = poly_q[j];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
            root_q <= ALPHA_FIRST;
        end else if (start) begin
            busy_q <= 1'b1;
            left_q <= npar;
            root_q <= ALPHA_FIRST;
        end else if (busy_q) begin
            root_q <= gf_xtime(root_q);
            left_q <= left_q - NPAR_W'(1);
            if (left_q == NPAR_W'(1)) busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/rs_lfsr_div.sv
module rs_lfsr_div
    import rs_enc_pkg::*;
#(
    parameter int MAXP = MAX_NPAR
) (
    input  logic                       clk,
    input  logic                       rst,
    input  lfsr_ctl_t                  ctl,
    input  sym_t                       din,
    input  logic [NPAR_W-1:0]          npar,
    input  logic [MAXP-1:0][SYM_W-1:0] gen_coef,
    output sym_t                       top
);

    sym_t reg_q [MAXP];
    sym_t base  [MAXP];
    sym_t nxt   [MAXP];
    sym_t fb;

    // Highest live stage is selected by the run-time parity count.
    always_comb begin
        top = '0;
        for (int i = 0; i < MAXP; i++) begin
            if (i == int'(npar) - 1) top = base[i];
        end
    end

    // Feedback forced to zero turns the division into a plain shift.
    assign fb = ctl.feed ? (din ^ top) : '0;

    for (genvar i = 0; i < MAXP; i++) begin : g_stage
        assign base[i] = ctl.clear ? '0 : reg_q[i];

        if (i == 0) begin : g_first
            assign nxt[i] = gf_mul(fb, gen_coef[i]);
        end else begin : g_rest
            assign nxt[i] = base[i-1] ^ gf_mul(fb, gen_coef[i]);
        end

        always_ff @(posedge clk) begin
            if (rst)           reg_q[i] <= '0;
            else if (ctl.step) reg_q[i] <= nxt[i];
        end
    end

endmodule

// File: rtl/rs_block_seq.sv
module rs_block_seq
    import rs_enc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [NPAR_W-1:0] cfg_npar,
    input  logic [LEN_W-1:0]  cfg_nlen,
    input  logic              in_valid,
    input  logic              in_sob,
    input  logic              busy,
    output logic [NPAR_W-1:0] npar,
    output logic              build_start,
    output logic              cfg_err,
    output lfsr_ctl_t         ctl
);

    cfg_t             cfg_q;
    logic [LEN_W-1:0] kdata_q;
    logic [LEN_W-1:0] pos_q;
    logic [LEN_W-1:0] cur_pos;
    logic [LEN_W-1:0] nxt_pos;
    logic             ready_q;
    logic             err_q;
    logic             legal;
    logic             accept;
    logic             start_blk;
    logic             cont;
    logic             last;
    seq_state_e       state_q;
    seq_state_e       state_d;

    assign legal       = cfg_ok(cfg_npar, cfg_nlen);
    assign build_start = cfg_load && legal;

    // A load in the same cycle wins over the byte.
    assign accept    = in_valid && ready_q && !err_q && !busy && !cfg_load;
    assign start_blk = accept && in_sob;
    assign cont      = accept && !in_sob && (state_q != SEQ_IDLE);

    assign cur_pos = start_blk ? '0 : pos_q;
    assign nxt_pos = cur_pos + LEN_W'(1);
    assign last    = (cur_pos == cfg_q.nlen - LEN_W'(1));

    assign ctl.step  = start_blk || cont;
    assign ctl.clear = start_blk;
    assign ctl.feed  = start_blk || (state_q == SEQ_DATA);

    always_comb begin
        state_d = state_q;
        if (cfg_load) begin
            state_d = SEQ_IDLE;
        end else if (ctl.step) begin
            if (last)                  state_d = SEQ_IDLE;
            else if (nxt_pos < kdata_q) state_d = SEQ_DATA;
            else                       state_d = SEQ_PARITY;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            kdata_q <= '0;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
            pos_q   <= '0;
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
            if (cfg_load) begin
                cfg_q.npar <= cfg_npar;
                cfg_q.nlen <= cfg_nlen;
                kdata_q    <= cfg_nlen - LEN_W'(cfg_npar);
                ready_q    <= legal;
                err_q      <= !legal;
            end
            if (ctl.step) pos_q <= nxt_pos;
        end
    end

    assign npar    = cfg_q.npar;
    assign cfg_err = err_q;

endmodule

// File: rtl/rs_encoder.sv
module rs_encoder
    import rs_enc_pkg::*;
#(
    parameter int MAXP = MAX_NPAR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [NPAR_W-1:0] cfg_npar,
    input  logic [LEN_W-1:0]  cfg_nlen,
    input  logic              in_valid,
    input  logic              in_sob,
    input  logic [SYM_W-1:0]  in_data,
    output logic              out_valid,
    output logic              out_sob,
    output logic [SYM_W-1:0]  out_data,
    output logic              busy,
    output logic              cfg_err
);

    logic [MAXP-1:0][SYM_W-1:0] gen_coef;
    logic [NPAR_W-1:0]          npar;
    logic                       build_start;
    lfsr_ctl_t                  ctl;
    sym_t                       top;

    rs_block_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg_load    (cfg_load),
        .cfg_npar    (cfg_npar),
        .cfg_nlen    (cfg_nlen),
        .in_valid    (in_valid),
        .in_sob      (in_sob),
        .busy        (busy),
        .npar        (npar),
        .build_start (build_start),
        .cfg_err     (cfg_err),
        .ctl         (ctl)
    );

    rs_gen_builder #(.MAXP(MAXP)) u_gen (
        .clk      (clk),
        .rst      (rst),
        .start    (build_start),
        .npar     (cfg_npar),
        .busy     (busy),
        .gen_coef (gen_coef)
    );

    rs_lfsr_div #(.MAXP(MAXP)) u_div (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .din      (in_data),
        .npar     (npar),
        .gen_coef (gen_coef),
        .top      (top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sob   <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= ctl.step;
            out_sob   <= ctl.step && ctl.clear;
            if (ctl.step) out_data <= ctl.feed ? in_data : top;
        end
    end

endmodule

// File: rtl/rs_encoder_chk.sv
module rs_encoder_chk
    import rs_enc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic [NPAR_W-1:0] cfg_npar,
    input logic [LEN_W-1:0]  cfg_nlen,
    input logic              in_valid,
    input logic              in_sob,
    input logic              out_valid,
    input logic              out_sob,
    input logic              busy,
    input logic              cfg_err
);

    logic              legal;
    logic [NPAR_W-1:0] cap_npar;
    logic [NPAR_W:0]   busy_run;

    assign legal = cfg_ok(cfg_npar, cfg_nlen);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_npar <= '0;
            busy_run <= '0;
        end else if (cfg_load && legal) begin
            cap_npar <= cfg_npar;
            busy_run <= '0;
        end else if (busy) begin
            busy_run <= busy_run + 1'b1;
        end
    end

    p_busy_from_load_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cfg_load));

    p_busy_length_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == {1'b0, cap_npar}));

    p_legal_load_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && legal) |=> (!cfg_err && busy));

    p_illegal_load_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && !legal) |=> cfg_err);

    p_no_out_on_err_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(cfg_err));

    p_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    p_sob_marks_r6: assert property (@(posedge clk) disable iff (rst)
        out_sob |-> (out_valid && $past(in_sob)));

    p_drop_when_busy_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(busy));

    p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$past(cfg_load));

endmodule

bind rs_encoder rs_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_npar  (cfg_npar),
    .cfg_nlen  (cfg_nlen),
    .in_valid  (in_valid),
    .in_sob    (in_sob),
    .out_valid (out_valid),
    .out_sob   (out_sob),
    .busy      (busy),
    .cfg_err   (cfg_err)
);

// File: tb/tb_rs_encoder.sv
module tb_rs_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [4:0] cfg_npar = '0;
    logic [7:0] cfg_nlen = '0;
    logic       in_valid = 1'b0;
    logic       in_sob = 1'b0;
    logic [7:0] in_data = '0;
    logic       out_valid;
    logic       out_sob;
    logic [7:0] out_data;
    logic       busy;
    logic       cfg_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int cur_np = 0;
    int cur_n = 0;

    logic [7:0] gpoly [0:20];
    logic [7:0] msg   [0:254];
    logic [7:0] cw    [0:254];
    logic [7:0] got   [0:254];
    logic [7:0] keep  [0:254];

    always #10 clk = ~clk;

    rs_encoder dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_npar  (cfg_npar),
        .cfg_nlen  (cfg_nlen),
        .in_valid  (in_valid),
        .in_sob    (in_sob),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sob   (out_sob),
        .out_data  (out_data),
        .busy      (busy),
        .cfg_err   (cfg_err)
    );

    function automatic logic [7:0] m_xt(logic [7:0] a);
        return a[7] ? ({a[6:0], 1'b0} ^ 8'h87) : {a[6:0], 1'b0};
    endfunction

    function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc = '0;
        logic [7:0] t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= t;
            t = m_xt(t);
        end
        return acc;
    endfunction

    function automatic logic [7:0] m_apow(int e);
        logic [7:0] t = 8'h01;
        for (int i = 0; i < e; i++) t = m_xt(t);
        return t;
    endfunction

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic build_ref(int np);
        logic [7:0] root;
        for (int j = 0; j <= 20; j++) gpoly[j] = 8'h00;
        gpoly[0] = 8'h01;
        root = m_apow(120);
        for (int k = 0; k < np; k++) begin
            for (int j = np; j >= 1; j--) gpoly[j] = gpoly[j-1] ^ m_mul(gpoly[j], root);
            gpoly[0] = m_mul(gpoly[0], root);
            root = m_xt(root);
        end
    endtask

    task automatic encode_ref(int np, int n);
        logic [7:0] rem [0:19];
        logic [7:0] fb;
        int kd = n - np;
        build_ref(np);
        for (int i = 0; i < 20; i++) rem[i] = 8'h00;
        for (int k = 0; k < kd; k++) begin
            cw[k] = msg[k];
            fb = msg[k] ^ rem[np-1];
            for (int i = np - 1; i >= 1; i--) rem[i] = rem[i-1] ^ m_mul(fb, gpoly[i]);
            rem[0] = m_mul(fb, gpoly[0]);
        end
        for (int j = 0; j < np; j++) cw[kd + j] = rem[np - 1 - j];
    endtask

    task automatic send_byte(logic [7:0] d, bit sob, bit ev, logic [7:0] ed, bit es, string req);
        in_valid = 1'b1;
        in_sob   = sob;
        in_data  = d;
        @(negedge clk);
        in_valid = 1'b0;
        in_sob   = 1'b0;
        chk(out_valid == ev, req, "out_valid", int'(out_valid), int'(ev));
        if (ev && out_valid) begin
            chk(out_data == ed, req, "out_data", int'(out_data), int'(ed));
            chk(out_sob == es, "R6", "out_sob", int'(out_sob), int'(es));
        end
    endtask

    task automatic configure(int np, int n, bit ok);
        int cnt = 0;
        cfg_load = 1'b1;
        cfg_npar = 5'(np);
        cfg_nlen = 8'(n);
        @(negedge clk);
        cfg_load = 1'b0;
        chk(cfg_err == !ok, ok ? "R2" : "R3", "cfg_err after load", int'(cfg_err), int'(!ok));
        if (ok) begin
            while (busy && cnt < 100) begin
                cnt++;
                @(negedge clk);
            end
            chk(cnt == np, "R2", "busy cycles", cnt, np);
            cur_np = np;
            cur_n  = n;
        end else begin
            chk(busy == 1'b0, "R3", "busy on illegal load", int'(busy), 0);
        end
    endtask

    task automatic new_msg();
        for (int i = 0; i < 255; i++) msg[i] = 8'($urandom);
    endtask

    // ph_mode: 0 zeros, 1 all ones, 2 random placeholders
    task automatic run_block(int gap_pct, int ph_mode);
        int kd = cur_n - cur_np;
        int bad = 0;
        logic [7:0] d;
        logic [7:0] v;
        logic [7:0] root;
        encode_ref(cur_np, cur_n);
        for (int p = 0; p < cur_n; p++) begin
            if (p > 0 && int'($urandom % 100) < gap_pct) begin
                @(negedge clk);
                chk(out_valid == 1'b0, "R6", "idle gap output", int'(out_valid), 0);
            end
            if (p < kd)            d = msg[p];
            else if (ph_mode == 0) d = 8'h00;
            else if (ph_mode == 1) d = 8'hFF;
            else                   d = 8'($urandom);
            send_byte(d, p == 0, 1'b1, cw[p], p == 0,
                      (p < kd) ? "R7" : ((p == kd) ? "R8" : "R5"));
            got[p] = out_data;
        end
        root = m_apow(120);
        for (int k = 0; k < cur_np; k++) begin
            v = 8'h00;
            for (int p = 0; p < cur_n; p++) v = m_mul(v, root) ^ got[p];
            if (v != 8'h00) bad++;
            root = m_xt(root);
        end
        chk(bad == 0, "R4", "roots not zero", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int seed_init;
        int np;
        int n;
        seed_init = $urandom(20240611);

        // R1: reset state
        repeat (4) @(negedge clk);
        chk(out_valid == 0 && out_sob == 0, "R1", "outputs in reset", int'(out_valid), 0);
        chk(busy == 0 && cfg_err == 0, "R1", "flags in reset", int'({busy, cfg_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        send_byte(8'h5A, 1'b1, 1'b0, 8'h00, 1'b0, "R1");

        // R3: illegal configurations
        configure(1, 10, 1'b0);
        send_byte(8'h11, 1'b1, 1'b0, 8'h00, 1'b0, "R3");
        configure(21, 30, 1'b0);
        configure(4, 4, 1'b0);
        configure(5, 0, 1'b0);
        repeat (3) @(negedge clk);
        chk(cfg_err == 1'b1, "R3", "cfg_err held", int'(cfg_err), 1);
        send_byte(8'h22, 1'b1, 1'b0, 8'h00, 1'b0, "R3");

        // R2 / R5: minimum legal block, then back-to-back
        configure(2, 3, 1'b1);
        new_msg(); run_block(0, 0);
        new_msg(); run_block(0, 2);

        // R10: byte during busy is dropped
        cfg_load = 1'b1; cfg_npar = 5'd6; cfg_nlen = 8'd20;
        @(negedge clk);
        cfg_load = 1'b0;
        chk(busy == 1'b1, "R10", "busy after load", int'(busy), 1);
        send_byte(8'h33, 1'b1, 1'b0, 8'h00, 1'b0, "R10");
        while (busy) @(negedge clk);
        cur_np = 6; cur_n = 20;
        new_msg(); run_block(20, 2);

        // R9: stray byte, then mid-block restart
        send_byte(8'h44, 1'b0, 1'b0, 8'h00, 1'b0, "R9");
        new_msg(); encode_ref(cur_np, cur_n);
        send_byte(msg[0], 1'b1, 1'b1, cw[0], 1'b1, "R9");
        send_byte(msg[1], 1'b0, 1'b1, cw[1], 1'b0, "R9");
        new_msg(); run_block(0, 1);

        // R7: same message, different placeholders
        new_msg(); run_block(0, 0);
        for (int p = 0; p < cur_n; p++) keep[p] = got[p];
        run_block(30, 1);
        begin
            int diff = 0;
            for (int p = 0; p < cur_n; p++) if (keep[p] != got[p]) diff++;
            chk(diff == 0, "R7", "placeholder influence", diff, 0);
        end

        // R11: load coincident with a byte mid-block
        configure(4, 12, 1'b1);
        new_msg(); encode_ref(cur_np, cur_n);
        send_byte(msg[0], 1'b1, 1'b1, cw[0], 1'b1, "R11");
        send_byte(msg[1], 1'b0, 1'b1, cw[1], 1'b0, "R11");
        cfg_load = 1'b1; cfg_npar = 5'd7; cfg_nlen = 8'd16;
        in_valid = 1'b1; in_sob = 1'b0; in_data = msg[2];
        @(negedge clk);
        cfg_load = 1'b0; in_valid = 1'b0;
        chk(out_valid == 1'b0, "R11", "byte with load", int'(out_valid), 0);
        while (busy) @(negedge clk);
        cur_np = 7; cur_n = 16;
        send_byte(msg[3], 1'b0, 1'b0, 8'h00, 1'b0, "R11");
        new_msg(); run_block(0, 2);

        // R8: largest block
        configure(20, 255, 1'b1);
        new_msg(); run_block(0, 2);

        // constrained random configurations
        for (int it = 0; it < 12; it++) begin
            np = 2 + int'($urandom % 19);
            n  = np + 1 + int'($urandom % (255 - np));
            configure(np, n, 1'b1);
            new_msg(); run_block(25, 2);
            new_msg(); run_block(0, int'($urandom % 3));
        end

        repeat (3) @(negedge clk);
        report();
    end

endmodule